// File: doc/BRIEF.md
# Storage Device Reset Sequencer

This block is the device-side sequencer that a serial storage link uses for its reset and self-test flows. It covers the hardware reset announced out of band, the soft reset carried in a received frame, the device-reset command and the self-diagnostic command. It drives request lines toward the rest of the device: start diagnostics, halt all activity, and transmit a register-type status frame marked good or bad. It also flags when the device sits idle and is ready for host traffic. Each request is a level that stays high until its acknowledge arrives. Framing, CRC and the diagnostics themselves live outside the block.

The out-of-band reset wins over everything. From any state, including a diagnostic run, a halt or a pending status send, it drops the block into a reset wait. The block stays there until the physical layer reports that reset has been released. It then runs power-up diagnostics and sends a status frame that reflects the diagnostic result. The diagnostic command follows the same path from idle. The device-reset command and the soft-reset frame both halt activity first and then always report good status.

Top module: `dev_reset_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it is released, `diag_start_o`, `halt_req_o`, `tx_req_o`, `tx_good_o` and `idle_o` are all 0. The block starts in the reset-wait state.
- R2: When `oob_reset_i` is 1 at a clock edge, all four request and idle outputs are 0 in the following cycle, whatever the block was doing. A diagnostic run, a halt or a status send in progress is abandoned.
- R3: In the reset-wait state the outputs stay 0 while `phy_rst_neg_i` is 0. The first edge with `phy_rst_neg_i`=1 and `oob_reset_i`=0 raises `diag_start_o` in the next cycle.
- R4: `diag_start_o` stays 1 until an edge with `diag_done_i`=1. In the next cycle `diag_start_o` is 0, `tx_req_o` is 1, and `tx_good_o` equals the `diag_pass_i` sampled with `diag_done_i`.
- R5: `tx_req_o` stays 1, with `tx_good_o` unchanged, until an edge with `tx_done_i`=1. In the next cycle `idle_o` is 1.
- R6: In idle, a frame strobe `frm_valid_i`=1 with the soft-reset bit `frm_srst_i`=1 raises `halt_req_o` in the next cycle. This holds whatever the values of the control bit and the command inputs.
- R7: In idle, a frame strobe with `frm_srst_i`=0, control bit `frm_cbit_i`=1 and `cmd_devrst_i`=1 raises `halt_req_o` in the next cycle. The device-reset command has priority over `cmd_diag_i`.
- R8: In idle, a frame strobe with `frm_srst_i`=0, `frm_cbit_i`=1, `cmd_devrst_i`=0 and `cmd_diag_i`=1 raises `diag_start_o` in the next cycle.
- R9: `halt_req_o` stays 1 until an edge with `halt_done_i`=1. In the next cycle `tx_req_o` is 1 with `tx_good_o`=1.
- R10: The block stays in idle for three cases: a frame with neither bit set, a control-bit frame with no reset or diagnostic command, and command inputs without a frame strobe. Frame and command inputs outside idle have no effect.
- R11: At most one of `diag_start_o`, `halt_req_o`, `tx_req_o` and `idle_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oob_reset_i | input | 1 | Out-of-band hardware reset indication |
| phy_rst_neg_i | input | 1 | Physical layer reports reset released |
| frm_valid_i | input | 1 | Received control frame strobe |
| frm_cbit_i | input | 1 | Control (command) bit of the frame |
| frm_srst_i | input | 1 | Soft-reset bit of the frame |
| cmd_diag_i | input | 1 | Decoded self-diagnostic command |
| cmd_devrst_i | input | 1 | Decoded device-reset command |
| diag_done_i | input | 1 | Diagnostics finished |
| diag_pass_i | input | 1 | Diagnostic result, 1 = passed, valid with done |
| halt_done_i | input | 1 | All activity has stopped |
| tx_done_i | input | 1 | Status frame transmitted |
| diag_start_o | output | 1 | Request to run diagnostics |
| halt_req_o | output | 1 | Request to halt all activity |
| tx_req_o | output | 1 | Request to send a register status frame |
| tx_good_o | output | 1 | Status is good (1) or bad (0), valid with tx_req_o |
| idle_o | output | 1 | Device idle |

## Verification
The power-up path is run twice, once with failing and once with passing diagnostics, which shows that the status flag follows the sampled result and is not a constant. Idle frames are tried in several shapes: no bits, control bit alone, soft reset combined with conflicting commands, device reset, and diagnostic. These separate the branch priority from the ignore cases. The out-of-band reset is applied during a halt, during diagnostics, and together with reset release, which confirms that it overrides every state. Frames sent during a status send or a diagnostic run show that inputs outside idle are ignored.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RST_WAIT = 3'd0,
    ST_DIAG     = 3'd1,
    ST_HALT     = 3'd2,
    ST_STATUS   = 3'd3,
    ST_IDLE     = 3'd4
  } rsq_state_e;

  typedef struct packed {
    logic diag;
    logic halt;
    logic tx;
    logic idle;
  } rsq_req_t;

  function automatic rsq_req_t rsq_decode(input rsq_state_e s);
    rsq_req_t r;
    r = '0;
    case (s)
      ST_DIAG:   r.diag = 1'b1;
      ST_HALT:   r.halt = 1'b1;
      ST_STATUS: r.tx   = 1'b1;
      ST_IDLE:   r.idle = 1'b1;
      default:   r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       oob_i,
  input  logic       phy_neg_i,
  input  logic       frm_valid_i,
  input  logic       frm_cbit_i,
  input  logic       frm_srst_i,
  input  logic       cmd_diag_i,
  input  logic       cmd_devrst_i,
  input  logic       diag_done_i,
  input  logic       halt_done_i,
  input  logic       tx_done_i,
  output rsq_state_e state_q,
  output rsq_state_e state_d
);

  logic go_halt, go_diag;

  // idle-branch decode; soft reset outranks device reset, which outranks diagnostics
  assign go_halt = frm_valid_i & (frm_srst_i | (frm_cbit_i & cmd_devrst_i));
  assign go_diag = frm_valid_i & ~frm_srst_i & frm_cbit_i & ~cmd_devrst_i & cmd_diag_i;

  always_comb begin
    state_d = state_q;
    if (oob_i) begin
      state_d = ST_RST_WAIT;
    end else begin
      case (state_q)
        ST_RST_WAIT: if (phy_neg_i)   state_d = ST_DIAG;
        ST_DIAG:     if (diag_done_i) state_d = ST_STATUS;
        ST_HALT:     if (halt_done_i) state_d = ST_STATUS;
        ST_STATUS:   if (tx_done_i)   state_d = ST_IDLE;
        ST_IDLE: begin
          if (go_halt)      state_d = ST_HALT;
          else if (go_diag) state_d = ST_DIAG;
        end
        default: state_d = ST_RST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RST_WAIT;
    else     state_q <= state_d;
  end

  // R3: wait holds while the physical layer keeps reset asserted
  assert_hold_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RST_WAIT && !phy_neg_i) |=> (state_q == ST_RST_WAIT));

  // R4: diagnostics stay requested until done
  assert_diag_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DIAG && !diag_done_i && !oob_i) |=> (state_q == ST_DIAG));

  // R6: soft-reset frame in idle leads to halt
  assert_srst_halt_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && frm_valid_i && frm_srst_i && !oob_i) |=> (state_q == ST_HALT));

endmodule

// File: rtl/rsq_status.sv
module rsq_status
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rsq_state_e state_q,
  input  logic       diag_done_i,
  input  logic       diag_pass_i,
  input  logic       halt_done_i,
  output logic       good_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      good_o <= 1'b0;
    end else if (state_q == ST_DIAG && diag_done_i) begin
      good_o <= diag_pass_i;
    end else if (state_q == ST_HALT && halt_done_i) begin
      good_o <= 1'b1;
    end
  end

  // R5: flag is frozen while the status frame is outstanding
  assert_flag_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STATUS) |=> $stable(good_o));

endmodule

// File: rtl/rsq_outreg.sv
module rsq_outreg
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rsq_state_e state_d,
  input  logic       tx_done_i,
  input  logic       oob_i,
  output rsq_req_t   req_o
);

  always_ff @(posedge clk) begin
    if (rst) req_o <= '0;
    else     req_o <= rsq_decode(state_d);
  end

  // R11: requests and idle are mutually exclusive
  assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_o.diag, req_o.halt, req_o.tx, req_o.idle}));

  // R5: transmit request held until acknowledged, then idle
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (req_o.tx && !tx_done_i && !oob_i) |=> req_o.tx);
  assert_tx_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (req_o.tx && tx_done_i && !oob_i) |=> req_o.idle);

endmodule

// File: rtl/dev_reset_seq.sv
module dev_reset_seq
  import rsq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic oob_reset_i,
  input  logic phy_rst_neg_i,
  input  logic frm_valid_i,
  input  logic frm_cbit_i,
  input  logic frm_srst_i,
  input  logic cmd_diag_i,
  input  logic cmd_devrst_i,
  input  logic diag_done_i,
  input  logic diag_pass_i,
  input  logic halt_done_i,
  input  logic tx_done_i,
  output logic diag_start_o,
  output logic halt_req_o,
  output logic tx_req_o,
  output logic tx_good_o,
  output logic idle_o
);

  rsq_state_e state_q, state_d;
  rsq_req_t   req;
  logic       good;

  rsq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .oob_i        (oob_reset_i),
    .phy_neg_i    (phy_rst_neg_i),
    .frm_valid_i  (frm_valid_i),
    .frm_cbit_i   (frm_cbit_i),
    .frm_srst_i   (frm_srst_i),
    .cmd_diag_i   (cmd_diag_i),
    .cmd_devrst_i (cmd_devrst_i),
    .diag_done_i  (diag_done_i),
    .halt_done_i  (halt_done_i),
    .tx_done_i    (tx_done_i),
    .state_q      (state_q),
    .state_d      (state_d)
  );

  rsq_status u_status (
    .clk         (clk),
    .rst         (rst),
    .state_q     (state_q),
    .diag_done_i (diag_done_i),
    .diag_pass_i (diag_pass_i),
    .halt_done_i (halt_done_i),
    .good_o      (good)
  );

  rsq_outreg u_outreg (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .tx_done_i (tx_done_i),
    .oob_i     (oob_reset_i),
    .req_o     (req)
  );

  assign diag_start_o = req.diag;
  assign halt_req_o   = req.halt;
  assign tx_req_o     = req.tx;
  assign idle_o       = req.idle;
  assign tx_good_o    = req.tx & good;

  // R2: out-of-band reset clears every request in the next cycle
  assert_oob_clear_R2: assert property (@(posedge clk) disable iff (rst)
    oob_reset_i |=> !(diag_start_o || halt_req_o || tx_req_o || idle_o));

  // R9: halt acknowledge leads to good status
  assert_halt_good_R9: assert property (@(posedge clk) disable iff (rst)
    (halt_req_o && halt_done_i && !oob_reset_i) |=> (tx_req_o && tx_good_o));

  // R4: diagnostic completion leads to status carrying the result
  assert_diag_status_R4: assert property (@(posedge clk) disable iff (rst)
    (diag_start_o && diag_done_i && !oob_reset_i) |=> (tx_req_o && (tx_good_o == $past(diag_pass_i))));

endmodule

// File: tb/dev_reset_seq_tb.sv
`timescale 1ns/1ps
module dev_reset_seq_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oob = 0, phy = 0, fv = 0, fc = 0, fs = 0, cd = 0, cr = 0;
  logic dd = 0, dp = 0, hd = 0, td = 0;
  logic diag_start, halt_req, tx_req, tx_good, idle;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dev_reset_seq u_dut (
    .clk(clk), .rst(rst), .oob_reset_i(oob), .phy_rst_neg_i(phy),
    .frm_valid_i(fv), .frm_cbit_i(fc), .frm_srst_i(fs),
    .cmd_diag_i(cd), .cmd_devrst_i(cr), .diag_done_i(dd), .diag_pass_i(dp),
    .halt_done_i(hd), .tx_done_i(td),
    .diag_start_o(diag_start), .halt_req_o(halt_req), .tx_req_o(tx_req),
    .tx_good_o(tx_good), .idle_o(idle)
  );

  // behavioural reference: phase names as strings, result flag as a bit
  string phase = "wait";
  bit    rgood = 0;

  always @(posedge clk) begin
    if (rst) begin
      phase <= "wait"; rgood <= 0;
    end else if (oob) begin
      phase <= "wait";
    end else if (phase == "wait") begin
      if (phy) phase <= "diag";
    end else if (phase == "diag") begin
      if (dd) begin phase <= "send"; rgood <= dp; end
    end else if (phase == "halt") begin
      if (hd) begin phase <= "send"; rgood <= 1; end
    end else if (phase == "send") begin
      if (td) phase <= "idle";
    end else if (fv && (fs || (fc && cr))) begin
      phase <= "halt";
    end else if (fv && fc && cd) begin
      phase <= "diag";
    end
  end

  function automatic logic [4:0] model_vec();
    logic g;
    g = (phase == "send") ? rgood : 1'b0;
    return {phase == "diag", phase == "halt", phase == "send", phase == "idle", g};
  endfunction

  function automatic string phase_tag();
    if (phase == "wait") return "R2/R3";
    if (phase == "diag") return "R4";
    if (phase == "halt") return "R9";
    if (phase == "send") return "R5";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] dut_vec();
    return {diag_start, halt_req, tx_req, tx_good, idle};
  endfunction

  // every-cycle comparison against the model, plus exclusivity (R11)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [4:0] m;
      m = model_vec();
      chk(phase_tag(), dut_vec(), {m[4], m[3], m[2], m[0], m[1]});
      chk("R11", {4'b0, $countones({diag_start, halt_req, tx_req, idle}) > 1}, 5'b0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic c, input logic s, input logic d, input logic r);
    fv = 1; fc = c; fs = s; cd = d; cr = r;
    step(1);
    fv = 0; fc = 0; fs = 0; cd = 0; cr = 0;
  endtask

  // vector order: diag, halt, tx, good, idle
  initial begin
    step(3);
    chk("R1", dut_vec(), 5'b00000);
    rst = 0;
    step(1);
    chk("R1", dut_vec(), 5'b00000);
    step(2);
    chk("R3", dut_vec(), 5'b00000);
    phy = 1; step(1);
    chk("R3", dut_vec(), 5'b10000);
    step(2);
    dd = 1; dp = 0; step(1); dd = 0;
    chk("R4", dut_vec(), 5'b00100);
    step(2);
    chk("R5", dut_vec(), 5'b00100);
    td = 1; step(1); td = 0;
    chk("R5", dut_vec(), 5'b00001);

    frame(0, 0, 1, 1);
    chk("R10", dut_vec(), 5'b00001);
    cd = 1; cr = 1; step(1); cd = 0; cr = 0;
    chk("R10", dut_vec(), 5'b00001);
    frame(1, 0, 0, 0);
    chk("R10", dut_vec(), 5'b00001);

    frame(1, 1, 1, 0);
    chk("R6", dut_vec(), 5'b01000);
    step(2);
    chk("R9", dut_vec(), 5'b01000);
    hd = 1; step(1); hd = 0;
    chk("R9", dut_vec(), 5'b00110);
    td = 1; step(1); td = 0;
    chk("R5", dut_vec(), 5'b00001);

    frame(1, 0, 1, 1);
    chk("R7", dut_vec(), 5'b01000);
    oob = 1; phy = 0; step(1);
    chk("R2", dut_vec(), 5'b00000);
    oob = 0; step(2);
    chk("R3", dut_vec(), 5'b00000);
    oob = 1; phy = 1; step(1);
    chk("R2", dut_vec(), 5'b00000);
    oob = 0; step(1);
    chk("R3", dut_vec(), 5'b10000);
    dd = 1; dp = 1; step(1); dd = 0; dp = 0;
    chk("R4", dut_vec(), 5'b00110);
    frame(0, 1, 0, 1);
    chk("R10", dut_vec(), 5'b00110);
    td = 1; step(1); td = 0;
    chk("R5", dut_vec(), 5'b00001);

    frame(1, 0, 1, 0);
    chk("R8", dut_vec(), 5'b10000);
    frame(1, 1, 0, 1);
    chk("R10", dut_vec(), 5'b10000);
    oob = 1; step(1); oob = 0;
    chk("R2", dut_vec(), 5'b00000);
    step(1);
    chk("R3", dut_vec(), 5'b10000);
    dd = 1; dp = 1; step(1); dd = 0; dp = 0;
    chk("R4", dut_vec(), 5'b00110);
    td = 1; step(1); td = 0;
    chk("R5", dut_vec(), 5'b00001);
    step(2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule